// File: doc/BRIEF.md
# Device-Side Address Translation Cache

This block caches address translations for a device-facing IOMMU. A lookup supplies an input address, a 16-bit address-space identifier, a granule size given as log2 of the page size, a write flag and an indication that a translation table exists for the access. Entries are keyed by the identifier together with the input address with its in-page bits cleared. A hit answers one cycle after acceptance with the translated address and the entry's address mask, or with a permission fault. A miss issues a request to an external page-table walker and waits for its answer. A successful answer is returned to the requester and stored in the cache.

A separate command port removes entries. It can clear every entry, every entry of one identifier, or only the entry of one identifier that covers a given address. A fourth command clears everything and is meant for address-based invalidation across all identifiers. Eight entries are searched fully in parallel. When the cache is full, the next install empties the whole cache instead of choosing a victim. Two counters report lookups that hit and lookups that missed.

Top module: `iotlb_cache`

## Requirements
- R1: After reset `lkReady` is 1, `rspValid` and `walkReqValid` are 0, both counters are 0 and no lookup hits.
- R2: A lookup hits when an entry has the same identifier and its tag equals `lkAddr` with the low `lkGran` bits cleared. For a read, or for a write to a writable entry, the cycle after acceptance shows `rspValid`=1, `rspFault`=0, `rspAddr` = stored page base + (`lkAddr` & ((1<<`lkGran`)-1)) and `rspMask` = stored mask.
- R3: A write that hits an entry without write permission answers with `rspFault`=2, `rspAddr`=`lkAddr` and `rspMask`=0. Every faulting answer drives `rspMask`=0 and `rspRnw` = not `lkWrite`.
- R4: A lookup with `lkTtSel`=0 answers in the next cycle with `rspFault`=1 and `rspAddr`=`lkAddr`. It does not search the cache, does not start a walk and does not change either counter.
- R5: On a miss, `walkReqValid` rises one cycle after acceptance. It carries the aligned address, the identifier, the granule and the write flag, and it stays high with stable fields until `walkReqReady` is sampled high. `lkReady` stays 0 from acceptance until the answer is given.
- R6: When the walker answers with `walkRspErr`=0, the block answers `rspFault`=0 with `rspAddr` = `walkRspBase` + in-page offset and `rspMask`=`walkRspMask`, and it installs the entry. When `walkRspErr`=1, it answers `rspFault`=3 with the input address and installs nothing.
- R7: An install into a cache that already holds 8 valid entries first invalidates all of them.
- R8: A command with `cmdValid`=1 takes effect at the clock edge. `cmdOp`=0 clears all entries. `cmdOp`=1 clears the entries whose identifier equals `cmdAsid`. `cmdOp`=2 clears the entry with a matching identifier whose tag equals `cmdAddr` with that entry's own granule bits cleared. `cmdOp`=3 clears all entries.
- R9: A command accepted in the cycle a miss is accepted, or at any time before the walker's answer, is applied. The walk result that follows is still returned to the requester but is not installed.
- R10: `hitCount` rises by one for each accepted lookup that hits and `missCount` by one for each accepted lookup that misses. Lookups with `lkTtSel`=0 count as neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkValid | input | 1 | Lookup request present |
| lkReady | output | 1 | Lookup can be accepted |
| lkAddr | input | ADDR_W | Input address |
| lkAsid | input | ASID_W | Address-space identifier |
| lkGran | input | GRAN_W | log2 of the page size |
| lkWrite | input | 1 | 1 for a write access |
| lkTtSel | input | 1 | A translation table exists for this access |
| rspValid | output | 1 | One-cycle answer strobe |
| rspFault | output | 2 | 0 ok, 1 translation, 2 permission, 3 walk error |
| rspAddr | output | ADDR_W | Translated address, or faulting address |
| rspMask | output | ADDR_W | Address mask of the translation, 0 on fault |
| rspRnw | output | 1 | Read/not-write bit of the answered access |
| walkReqValid | output | 1 | Walk request present |
| walkReqReady | input | 1 | Walker takes the request |
| walkAddr | output | ADDR_W | Page-aligned address to walk |
| walkAsid | output | ASID_W | Identifier of the walk |
| walkGran | output | GRAN_W | Granule of the walk |
| walkWrite | output | 1 | Write flag of the walk |
| walkRspValid | input | 1 | Walker answer strobe |
| walkRspErr | input | 1 | Walk failed |
| walkRspBase | input | ADDR_W | Translated page base |
| walkRspMask | input | ADDR_W | Address mask of the translation |
| walkRspWritable | input | 1 | Page is writable |
| cmdValid | input | 1 | Invalidation command strobe |
| cmdOp | input | 2 | Command code as in R8 |
| cmdAsid | input | ASID_W | Identifier operand |
| cmdAddr | input | ADDR_W | Address operand |
| hitCount | output | CNT_W | Lookups that hit |
| missCount | output | CNT_W | Lookups that missed |

## Verification
The properties assume a walker that answers only after it has taken a request. They also assume that `walkRspValid` never arrives while no walk is pending, and that the granule is below the address width. The bench walker follows this rule: it raises its ready only while a request is shown and its answer strobe only after the hand-off. Its granules are 12 or 16. Commands are sent between lookups or inside the walk window, never in the same cycle as a lookup or a walker answer.

// File: rtl/iotlb_pkg.sv
package iotlb_pkg;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_TRANS = 2'd1,
    FLT_PERM  = 2'd2,
    FLT_WALK  = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    INV_ALL      = 2'd0,
    INV_ASID     = 2'd1,
    INV_PAGE     = 2'd2,
    INV_ADDR_ALL = 2'd3
  } inv_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } walk_state_e;

  typedef struct packed {
    logic latchReq;
    logic rspHit;
    logic rspTrans;
    logic rspWalkOk;
    logic rspWalkErr;
    logic install;
  } ctl_s;

endpackage

// File: rtl/iotlb_dp.sv
module iotlb_dp
  import iotlb_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ASID_W  = 16,
  parameter int GRAN_W  = 5,
  parameter int ENTRIES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_s              ctl,
  input  logic [ADDR_W-1:0] lkAddr,
  input  logic [ASID_W-1:0] lkAsid,
  input  logic [GRAN_W-1:0] lkGran,
  input  logic              lkWrite,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [ASID_W-1:0] cmdAsid,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [ADDR_W-1:0] walkRspBase,
  input  logic [ADDR_W-1:0] walkRspMask,
  input  logic              walkRspWritable,
  output logic              hitAny,
  output logic [ADDR_W-1:0] walkAddr,
  output logic [ASID_W-1:0] walkAsid,
  output logic [GRAN_W-1:0] walkGran,
  output logic              walkWrite,
  output logic              rspValid,
  output logic [1:0]        rspFault,
  output logic [ADDR_W-1:0] rspAddr,
  output logic [ADDR_W-1:0] rspMask,
  output logic              rspRnw
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  function automatic logic [ADDR_W-1:0] maskOf(input logic [GRAN_W-1:0] g);
    return (ADDR_W'(1) << g) - ADDR_W'(1);
  endfunction

  logic [ENTRIES-1:0] vld;
  logic [ASID_W-1:0]  asidQ [ENTRIES];
  logic [ADDR_W-1:0]  tagQ  [ENTRIES];
  logic [ADDR_W-1:0]  baseQ [ENTRIES];
  logic [ADDR_W-1:0]  maskQ [ENTRIES];
  logic [GRAN_W-1:0]  granQ [ENTRIES];
  logic [ENTRIES-1:0] wrQ;

  logic [ADDR_W-1:0]  lkMask, lkTag, pOrig;
  logic [ENTRIES-1:0] hitVec, killVec;

  assign lkMask = maskOf(lkGran);
  assign lkTag  = lkAddr & ~lkMask;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic asidEq;
    assign asidEq    = (asidQ[i] == lkAsid);
    assign hitVec[i] = vld[i] && asidEq && (tagQ[i] == lkTag);

    logic invHit;
    always_comb begin
      unique case (inv_e'(cmdOp))
        INV_ASID: invHit = (asidQ[i] == cmdAsid);
        INV_PAGE: invHit = (asidQ[i] == cmdAsid) &&
                           ((cmdAddr & ~maskOf(granQ[i])) == tagQ[i]);
        default:  invHit = 1'b1;
      endcase
    end
    assign killVec[i] = cmdValid && invHit;
  end

  logic [ADDR_W-1:0] selBase, selMask;
  logic              selWr;
  always_comb begin
    hitAny  = 1'b0;
    selBase = '0;
    selMask = '0;
    selWr   = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        hitAny  = 1'b1;
        selBase = baseQ[i];
        selMask = maskQ[i];
        selWr   = wrQ[i];
      end
    end
  end

  logic             full;
  logic [IDX_W-1:0] freeIdx, insIdx;
  always_comb begin
    freeIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!vld[i]) freeIdx = IDX_W'(i);
  end
  assign full   = &vld;
  assign insIdx = full ? '0 : freeIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vld <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (killVec[i] || (ctl.install && full)) vld[i] <= 1'b0;
        if (ctl.install && insIdx == IDX_W'(i)) vld[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (ctl.install && insIdx == IDX_W'(i)) begin
        asidQ[i] <= walkAsid;
        tagQ[i]  <= walkAddr;
        granQ[i] <= walkGran;
        baseQ[i] <= walkRspBase;
        maskQ[i] <= walkRspMask;
        wrQ[i]   <= walkRspWritable;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      walkAddr  <= '0;
      walkAsid  <= '0;
      walkGran  <= '0;
      walkWrite <= 1'b0;
      pOrig     <= '0;
    end else if (ctl.latchReq) begin
      walkAddr  <= lkTag;
      walkAsid  <= lkAsid;
      walkGran  <= lkGran;
      walkWrite <= lkWrite;
      pOrig     <= lkAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspFault <= FLT_NONE;
      rspAddr  <= '0;
      rspMask  <= '0;
      rspRnw   <= 1'b0;
    end else begin
      rspValid <= ctl.rspHit | ctl.rspTrans | ctl.rspWalkOk | ctl.rspWalkErr;
      if (ctl.rspHit) begin
        rspRnw <= !lkWrite;
        if (lkWrite && !selWr) begin
          rspFault <= FLT_PERM;
          rspAddr  <= lkAddr;
          rspMask  <= '0;
        end else begin
          rspFault <= FLT_NONE;
          rspAddr  <= selBase + (lkAddr & lkMask);
          rspMask  <= selMask;
        end
      end else if (ctl.rspTrans) begin
        rspRnw   <= !lkWrite;
        rspFault <= FLT_TRANS;
        rspAddr  <= lkAddr;
        rspMask  <= '0;
      end else if (ctl.rspWalkOk) begin
        rspRnw   <= !walkWrite;
        rspFault <= FLT_NONE;
        rspAddr  <= walkRspBase + (pOrig & maskOf(walkGran));
        rspMask  <= walkRspMask;
      end else if (ctl.rspWalkErr) begin
        rspRnw   <= !walkWrite;
        rspFault <= FLT_WALK;
        rspAddr  <= pOrig;
        rspMask  <= '0;
      end
    end
  end

endmodule

// File: rtl/iotlb_ctrl.sv
module iotlb_ctrl
  import iotlb_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lkValid,
  input  logic             lkTtSel,
  input  logic             hitAny,
  input  logic             cmdValid,
  input  logic             walkReqReady,
  input  logic             walkRspValid,
  input  logic             walkRspErr,
  output logic             lkReady,
  output logic             walkReqValid,
  output ctl_s             ctl,
  output logic [CNT_W-1:0] hitCount,
  output logic [CNT_W-1:0] missCount
);

  walk_state_e state;
  logic        discard, accept, rspNow;

  assign lkReady      = (state == ST_IDLE);
  assign walkReqValid = (state == ST_REQ);
  assign accept       = lkValid && lkReady;
  assign rspNow       = (state == ST_WAIT) && walkRspValid;

  always_comb begin
    ctl            = '0;
    ctl.rspTrans   = accept && !lkTtSel;
    ctl.rspHit     = accept && lkTtSel && hitAny;
    ctl.latchReq   = accept && lkTtSel && !hitAny;
    ctl.rspWalkOk  = rspNow && !walkRspErr;
    ctl.rspWalkErr = rspNow && walkRspErr;
    ctl.install    = rspNow && !walkRspErr && !discard && !cmdValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      discard   <= 1'b0;
      hitCount  <= '0;
      missCount <= '0;
    end else begin
      if (ctl.rspHit)   hitCount  <= hitCount + 1'b1;
      if (ctl.latchReq) missCount <= missCount + 1'b1;
      if (ctl.latchReq)           discard <= cmdValid;
      else if (!lkReady && cmdValid) discard <= 1'b1;
      unique case (state)
        ST_IDLE: if (ctl.latchReq) state <= ST_REQ;
        ST_REQ:  if (walkReqReady) state <= ST_WAIT;
        ST_WAIT: if (walkRspValid) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/iotlb_cache.sv
module iotlb_cache
  import iotlb_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ASID_W  = 16,
  parameter int GRAN_W  = 5,
  parameter int ENTRIES = 8,
  parameter int CNT_W   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lkValid,
  output logic              lkReady,
  input  logic [ADDR_W-1:0] lkAddr,
  input  logic [ASID_W-1:0] lkAsid,
  input  logic [GRAN_W-1:0] lkGran,
  input  logic              lkWrite,
  input  logic              lkTtSel,
  output logic              rspValid,
  output logic [1:0]        rspFault,
  output logic [ADDR_W-1:0] rspAddr,
  output logic [ADDR_W-1:0] rspMask,
  output logic              rspRnw,
  output logic              walkReqValid,
  input  logic              walkReqReady,
  output logic [ADDR_W-1:0] walkAddr,
  output logic [ASID_W-1:0] walkAsid,
  output logic [GRAN_W-1:0] walkGran,
  output logic              walkWrite,
  input  logic              walkRspValid,
  input  logic              walkRspErr,
  input  logic [ADDR_W-1:0] walkRspBase,
  input  logic [ADDR_W-1:0] walkRspMask,
  input  logic              walkRspWritable,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [ASID_W-1:0] cmdAsid,
  input  logic [ADDR_W-1:0] cmdAddr,
  output logic [CNT_W-1:0]  hitCount,
  output logic [CNT_W-1:0]  missCount
);

  ctl_s ctl;
  logic hitAny;

  iotlb_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkTtSel(lkTtSel),
    .hitAny(hitAny), .cmdValid(cmdValid), .walkReqReady(walkReqReady),
    .walkRspValid(walkRspValid), .walkRspErr(walkRspErr),
    .lkReady(lkReady), .walkReqValid(walkReqValid), .ctl(ctl),
    .hitCount(hitCount), .missCount(missCount)
  );

  iotlb_dp #(.ADDR_W(ADDR_W), .ASID_W(ASID_W), .GRAN_W(GRAN_W), .ENTRIES(ENTRIES)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .lkAddr(lkAddr), .lkAsid(lkAsid), .lkGran(lkGran), .lkWrite(lkWrite),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAsid(cmdAsid), .cmdAddr(cmdAddr),
    .walkRspBase(walkRspBase), .walkRspMask(walkRspMask),
    .walkRspWritable(walkRspWritable), .hitAny(hitAny),
    .walkAddr(walkAddr), .walkAsid(walkAsid), .walkGran(walkGran),
    .walkWrite(walkWrite), .rspValid(rspValid), .rspFault(rspFault),
    .rspAddr(rspAddr), .rspMask(rspMask), .rspRnw(rspRnw)
  );

endmodule

// File: rtl/iotlb_chk.sv
module iotlb_chk #(
  parameter int ADDR_W = 32,
  parameter int GRAN_W = 5,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              lkValid,
  input logic              lkReady,
  input logic              lkTtSel,
  input logic              walkReqValid,
  input logic              walkReqReady,
  input logic [ADDR_W-1:0] walkAddr,
  input logic [GRAN_W-1:0] walkGran,
  input logic              rspValid,
  input logic [1:0]        rspFault,
  input logic [ADDR_W-1:0] rspMask,
  input logic [CNT_W-1:0]  hitCount,
  input logic [CNT_W-1:0]  missCount
);

  logic [ADDR_W-1:0] gMask;
  assign gMask = (ADDR_W'(1) << walkGran) - ADDR_W'(1);

  AST_BUSY_STALL: assert property (@(posedge clk) disable iff (!rstN)
    walkReqValid |-> !lkReady); // R5

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    walkReqValid && !walkReqReady |=> walkReqValid && $stable(walkAddr)); // R5

  AST_WALK_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    walkReqValid |-> (walkAddr & gMask) == '0); // R5

  AST_NO_TABLE_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    lkValid && lkReady && !lkTtSel |=> rspValid && rspFault == 2'd1); // R4

  AST_FAULT_NO_MASK: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspFault != 2'd0 |-> rspMask == '0); // R3

  AST_HIT_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    hitCount != $past(hitCount) |-> $past(lkValid && lkReady && lkTtSel)); // R10

  AST_MISS_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    missCount != $past(missCount) |-> walkReqValid); // R10

endmodule

bind iotlb_cache iotlb_chk #(.ADDR_W(ADDR_W), .GRAN_W(GRAN_W), .CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkReady(lkReady), .lkTtSel(lkTtSel),
  .walkReqValid(walkReqValid), .walkReqReady(walkReqReady), .walkAddr(walkAddr),
  .walkGran(walkGran), .rspValid(rspValid), .rspFault(rspFault), .rspMask(rspMask),
  .hitCount(hitCount), .missCount(missCount)
);

// File: tb/sim_iotlb_cache.sv
`timescale 1ns/1ps
module sim_iotlb_cache;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lkValid = 0, lkWrite = 0, lkTtSel = 0;
  logic [31:0] lkAddr = '0;
  logic [15:0] lkAsid = '0;
  logic [4:0]  lkGran = '0;
  logic        lkReady, rspValid, rspRnw, walkReqValid, walkWrite;
  logic [1:0]  rspFault;
  logic [31:0] rspAddr, rspMask, walkAddr;
  logic [15:0] walkAsid;
  logic [4:0]  walkGran;
  logic        walkReqReady = 0, walkRspValid = 0, walkRspErr = 0, walkRspWritable = 0;
  logic [31:0] walkRspBase = '0, walkRspMask = '0;
  logic        cmdValid = 0;
  logic [1:0]  cmdOp = '0;
  logic [15:0] cmdAsid = '0;
  logic [31:0] cmdAddr = '0;
  logic [31:0] hitCount, missCount;

  always #5 clk = ~clk;

  iotlb_cache u0 (.*);

  int nChk = 0, nFail = 0;
  int mHits = 0, mMiss = 0;
  bit mv [8];
  logic [15:0] mAsid [8];
  logic [31:0] mTag [8], mBase [8], mMask [8];
  logic [4:0]  mGran [8];
  bit mWr [8];

  function automatic logic [31:0] pmask(input logic [4:0] g);
    return (32'd1 << g) - 32'd1;
  endfunction
  function automatic logic [31:0] wBase(input logic [31:0] a, input logic [15:0] s, input logic [4:0] g);
    return ((a ^ {s, 16'h0}) ^ 32'h8000_0000) & ~pmask(g);
  endfunction
  function automatic bit wWr(input logic [31:0] a);
    return !a[16];
  endfunction
  function automatic bit wErr(input logic [31:0] a);
    return a[19:16] == 4'hB;
  endfunction
  function automatic int find(input logic [31:0] a, input logic [15:0] s, input logic [4:0] g);
    for (int i = 0; i < 8; i++)
      if (mv[i] && mAsid[i] == s && mTag[i] == (a & ~pmask(g))) return i;
    return -1;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic modelCmd(input logic [1:0] op, input logic [15:0] s, input logic [31:0] a);
    for (int i = 0; i < 8; i++) begin
      if (op == 2'd1 && mAsid[i] == s) mv[i] = 0;
      else if (op == 2'd2 && mAsid[i] == s && (a & ~pmask(mGran[i])) == mTag[i]) mv[i] = 0;
      else if (op == 2'd0 || op == 2'd3) mv[i] = 0;
    end
  endtask

  task automatic modelInstall(input logic [31:0] t, input logic [15:0] s, input logic [4:0] g);
    int cnt = 0;
    int slot = -1;
    for (int i = 0; i < 8; i++) if (mv[i]) cnt++;
    if (cnt == 8) for (int i = 0; i < 8; i++) mv[i] = 0;   // R7 flush
    for (int i = 7; i >= 0; i--) if (!mv[i]) slot = i;
    mv[slot] = 1; mAsid[slot] = s; mTag[slot] = t; mGran[slot] = g;
    mBase[slot] = wBase(t, s, g); mMask[slot] = pmask(g); mWr[slot] = wWr(t);
  endtask

  task automatic doCmd(input logic [1:0] op, input logic [15:0] s, input logic [31:0] a);
    @(negedge clk);
    cmdValid = 1; cmdOp = op; cmdAsid = s; cmdAddr = a;
    @(negedge clk);
    cmdValid = 0;
    modelCmd(op, s, a);
  endtask

  task automatic doLook(input logic [31:0] a, input logic [15:0] s, input logic [4:0] g,
                        input logic w, input logic tt, input logic mid, input logic [1:0] op,
                        input logic [15:0] cs, input logic [31:0] ca, input string tag);
    logic [31:0] al = a & ~pmask(g);
    logic [1:0]  eF = 2'd0;
    logic [31:0] eA = a, eM = 32'd0;
    bit eWalk = 0;
    int idx = find(a, s, g);
    if (!tt) eF = 2'd1;
    else if (idx >= 0) begin
      mHits++;
      if (w && !mWr[idx]) eF = 2'd2;
      else begin eA = mBase[idx] + (a & pmask(g)); eM = mMask[idx]; end
    end else begin
      eWalk = 1; mMiss++;
      if (wErr(al)) eF = 2'd3;
      else begin eA = wBase(al, s, g) + (a & pmask(g)); eM = pmask(g); end
    end
    @(negedge clk);
    chk(lkReady == 1'b1, "R5 ready before lookup", lkReady, 1);
    lkValid = 1; lkAddr = a; lkAsid = s; lkGran = g; lkWrite = w; lkTtSel = tt;
    @(negedge clk);
    lkValid = 0;
    chk(walkReqValid == eWalk, {tag, " walk started"}, walkReqValid, eWalk);
    if (eWalk && walkReqValid) begin
      chk(walkAddr == al && walkAsid == s && walkGran == g && walkWrite == w,
          "R5 walk fields", walkAddr, al);
      chk(lkReady == 1'b0, "R5 stall during walk", lkReady, 0);
      repeat ($urandom_range(0, 2)) begin
        @(negedge clk);
        chk(walkReqValid == 1'b1, "R5 request held", walkReqValid, 1);
      end
      walkReqReady = 1;
      @(negedge clk);
      walkReqReady = 0;
      repeat ($urandom_range(0, 2)) @(negedge clk);
      if (mid) begin
        cmdValid = 1; cmdOp = op; cmdAsid = cs; cmdAddr = ca;
        @(negedge clk);
        cmdValid = 0;
        modelCmd(op, cs, ca);
      end
      walkRspValid = 1; walkRspErr = wErr(walkAddr);
      walkRspBase = wBase(walkAddr, walkAsid, walkGran);
      walkRspMask = pmask(walkGran); walkRspWritable = wWr(walkAddr);
      @(negedge clk);
      walkRspValid = 0;
      if (!wErr(al) && !mid) modelInstall(al, s, g);
    end else if (eWalk) begin
      repeat (20) begin
        if (walkReqValid) break;
        @(negedge clk);
      end
      walkReqReady = 1; @(negedge clk); walkReqReady = 0;
      walkRspValid = 1; walkRspErr = 1; @(negedge clk); walkRspValid = 0;
    end
    chk(rspValid == 1'b1, {tag, " response strobe"}, rspValid, 1);
    chk(rspFault == eF, {tag, " fault code"}, rspFault, eF);
    chk(rspAddr == eA, {tag, " response address"}, rspAddr, eA);
    chk(rspMask == eM, {tag, " response mask"}, rspMask, eM);
    chk(rspRnw == !w, "R3 rnw bit", rspRnw, !w);
  endtask

  initial begin
    #2_000_000;
    nFail++;
    $display("FAIL watchdog expired (all requirements) actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) mv[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(lkReady == 1 && rspValid == 0 && walkReqValid == 0, "R1 idle outputs",
        {lkReady, rspValid, walkReqValid}, 3'b100);
    chk(hitCount == 0 && missCount == 0, "R1 counters", hitCount + missCount, 0);

    doLook(32'h0001_2345, 16'd1, 5'd12, 0, 1, 0, 0, 0, 0, "R1 empty miss");
    doLook(32'h0001_2ABC, 16'd1, 5'd12, 0, 1, 0, 0, 0, 0, "R2 read hit");
    doLook(32'h0001_2000, 16'd1, 5'd12, 1, 1, 0, 0, 0, 0, "R3 write to read-only");
    doLook(32'h0000_3010, 16'd1, 5'd12, 1, 1, 0, 0, 0, 0, "R6 writable install");
    doLook(32'h0000_3FF0, 16'd1, 5'd12, 1, 1, 0, 0, 0, 0, "R2 write hit");
    doLook(32'h0001_2345, 16'd1, 5'd12, 0, 0, 0, 0, 0, 0, "R4 no table");
    doLook(32'h000B_0004, 16'd1, 5'd12, 0, 1, 0, 0, 0, 0, "R6 walk error");
    doLook(32'h000B_0004, 16'd1, 5'd12, 0, 1, 0, 0, 0, 0, "R6 error not installed");
    doLook(32'h0001_2345, 16'd2, 5'd12, 0, 1, 0, 0, 0, 0, "R2 other ASID misses");

    doCmd(2'd0, 0, 0);
    doLook(32'h0001_2345, 16'd1, 5'd12, 0, 1, 0, 0, 0, 0, "R8 clear all");
    doCmd(2'd0, 0, 0);
    for (int p = 0; p < 8; p++)
      doLook(32'h0000_0000 | (p << 16), 16'd2, 5'd16, 0, 1, 0, 0, 0, 0, "R7 fill");
    doLook(32'h0000_0040, 16'd2, 5'd16, 0, 1, 0, 0, 0, 0, "R7 full still hits");
    doLook(32'h0008_0000, 16'd2, 5'd16, 0, 1, 0, 0, 0, 0, "R7 install into full");
    doLook(32'h0001_0000, 16'd2, 5'd16, 0, 1, 0, 0, 0, 0, "R7 flushed entry");

    doLook(32'h0002_1000, 16'd3, 5'd12, 0, 1, 0, 0, 0, 0, "R8 setup");
    doLook(32'h0002_1000, 16'd4, 5'd12, 0, 1, 0, 0, 0, 0, "R8 setup");
    doCmd(2'd1, 16'd3, 0);
    doLook(32'h0002_1000, 16'd3, 5'd12, 0, 1, 0, 0, 0, 0, "R8 by-ASID removed");
    doLook(32'h0002_1000, 16'd4, 5'd12, 0, 1, 0, 0, 0, 0, "R8 other ASID kept");
    doLook(32'h0005_0000, 16'd5, 5'd16, 0, 1, 0, 0, 0, 0, "R8 setup");
    doLook(32'h0006_1000, 16'd5, 5'd12, 0, 1, 0, 0, 0, 0, "R8 setup");
    doCmd(2'd2, 16'd5, 32'h0005_ABCD);
    doCmd(2'd2, 16'd5, 32'h0006_2000);
    doLook(32'h0005_0100, 16'd5, 5'd16, 0, 1, 0, 0, 0, 0, "R8 page by entry granule");
    doLook(32'h0006_1100, 16'd5, 5'd12, 0, 1, 0, 0, 0, 0, "R8 page mismatch kept");
    doCmd(2'd3, 16'd9, 32'h1234_5000);
    doLook(32'h0002_1000, 16'd4, 5'd12, 0, 1, 0, 0, 0, 0, "R8 all-ASIDs by address");

    doLook(32'h0007_1000, 16'd6, 5'd12, 0, 1, 1, 2'd1, 16'd77, 0, "R9 command mid walk");
    doLook(32'h0007_1000, 16'd6, 5'd12, 0, 1, 0, 0, 0, 0, "R9 not installed");
    chk(hitCount == mHits, "R10 hit counter", hitCount, mHits);
    chk(missCount == mMiss, "R10 miss counter", missCount, mMiss);

    for (int n = 0; n < 400; n++) begin
      logic [31:0] a = ({28'd0, 4'($urandom_range(0, 11))} << 16) | {16'd0, 16'($urandom)};
      logic [15:0] s = 16'($urandom_range(1, 3));
      logic [4:0]  g = $urandom_range(0, 1) ? 5'd12 : 5'd16;
      logic [31:0] ca = ({28'd0, 4'($urandom_range(0, 11))} << 16) | {16'd0, 16'($urandom)};
      if ($urandom_range(0, 9) == 0)
        doCmd(2'($urandom), 16'($urandom_range(1, 3)), ca);
      doLook(a, s, g, 1'($urandom), $urandom_range(0, 15) != 0,
             $urandom_range(0, 7) == 0, 2'($urandom), 16'($urandom_range(1, 3)), ca,
             "R2 random lookup");
    end
    chk(hitCount == mHits, "R10 hit counter final", hitCount, mHits);
    chk(missCount == mMiss, "R10 miss counter final", missCount, mMiss);

    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

endmodule